// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block times one conversion of a successive-approximation converter from a fast input clock. A programmable prescaler turns the input clock into a basic conversion clock enable. A sample counter then holds the sample stage for a programmable number of basic clocks, counted in groups of four. After that, a bit stepper takes one basic clock per result bit, most significant bit first. Resolution is either 10 or 8 bits.

The analog comparator and the DAC are not part of this block. The block drives the current trial code on `sar_trial`. A single decision input, `cmp_in`, reports whether the trial is kept. Software writes one 16-bit control word that holds the mode, resolution, divider, sample-time and start fields, and reads the same word back with live status in it. A one-cycle `done` pulse marks the moment the result register is loaded.

Top module: `adc_seq_timer`

## Requirements
- R1: After reset, `ctrl_rd` reads 16'h1000: resolution bit 12 = 1 and all other bits 0. `busy`, `sampling` and `done` are 0 and `result` is 0.
- R2: A write with bit 13 = 1 while idle starts a conversion. `busy` is high from the clock after that write until the result is stored, and `ctrl_rd[13]` mirrors `busy`.
- R3: Let D be the divider field `ctrl[11:6]`. Every phase of the conversion advances once per D+1 input clocks.
- R4: Let S be the sample-time field `ctrl[5:0]`. `sampling` is high from the clock after the start for exactly 4*(S+1)*(D+1) input clocks, and `ctrl_rd[14]` mirrors it.
- R5: After sampling, each result bit takes one basic clock, most significant bit first. The bit is first set to 1 in `sar_trial` and is then kept if `cmp_in` = 1 or cleared if `cmp_in` = 0. With `cmp_in` = (sar_trial <= V), a 10-bit result equals V.
- R6: Resolution bit 12 = 0 selects 10 bits and 1 selects 8 bits. In 8-bit mode the result is left-aligned: bits 9..2 are decided and bits 1..0 read 0. A whole conversion lasts (4*(S+1)+N)*(D+1) input clocks, where N is the bit count.
- R7: `done` is high for exactly one clock. In that clock `result` holds the new value and `busy` has just fallen.
- R8: A start write that arrives while busy is ignored. The running conversion keeps its timing and end cycle.
- R9: Mode bit 15 is not changed by writes made while busy. It is updated by writes made while idle.
- R10: Divider, sample-time and resolution are captured at start. A write to these fields while busy does not change the running conversion, but it is visible in `ctrl_rd` and governs the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: [15] mode, [13] start, [12] resolution, [11:6] divider, [5:0] sample time |
| cmp_in | input | 1 | Comparator decision: 1 keeps the current trial bit |
| ctrl_rd | output | 16 | Control readback: [14] sampling and [13] busy are live status |
| busy | output | 1 | Conversion in progress |
| sampling | output | 1 | Sample phase in progress |
| done | output | 1 | One-clock pulse when the result is stored |
| result | output | 10 | Last conversion result |
| sar_trial | output | 10 | Trial code driven to the external DAC |

## Verification
On every cycle, the assertions check four things: sampling only happens inside busy; `done` is a single-clock pulse that coincides with the fall of `busy`; the mode bit holds steady through a conversion; and an 8-bit result has clear low bits. Only the directed scenarios can show the exact cycle counts of the prescaler and the sample phase, and that the stored code matches the bench's analog value at both resolutions. They also show that a restart attempt or a field write during a conversion leaves its end cycle unchanged, while the new fields govern the next conversion.

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int RES_W = 10,
  parameter int DIV_W = 6,
  parameter int ST_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              cmp_in,
  output logic [15:0]       ctrl_rd,
  output logic              busy,
  output logic              sampling,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic [RES_W-1:0]  sar_trial
);
  localparam int CNT_W = ST_W + 2;
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] MSB_IDX = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] LSB_8   = IDX_W'(RES_W - 8);
  localparam logic [RES_W-1:0] ONE     = RES_W'(1);

  logic             mode_q, res_q, busy_q, samp_q, done_q, res_l;
  logic [DIV_W-1:0] div_q, div_l, pcnt;
  logic [ST_W-1:0]  st_q, st_l;
  logic [CNT_W-1:0] scnt;
  logic [IDX_W-1:0] bidx;
  logic [RES_W-1:0] sar_q, result_q, sar_keep;

  wire start = wr_en && wr_data[13] && !busy_q;
  wire tick  = busy_q && (pcnt == div_l);
  wire [CNT_W-1:0] samp_last = {st_l, 2'b11};
  wire [IDX_W-1:0] lsb_idx = res_l ? LSB_8 : '0;

  always_comb begin
    sar_keep = sar_q;
    sar_keep[bidx] = cmp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      res_q    <= 1'b1;
      div_q    <= '0;
      st_q     <= '0;
      busy_q   <= 1'b0;
      samp_q   <= 1'b0;
      done_q   <= 1'b0;
      res_l    <= 1'b0;
      div_l    <= '0;
      st_l     <= '0;
      pcnt     <= '0;
      scnt     <= '0;
      bidx     <= '0;
      sar_q    <= '0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_en) begin
        if (!busy_q) mode_q <= wr_data[15];
        res_q <= wr_data[12];
        div_q <= wr_data[6 +: DIV_W];
        st_q  <= wr_data[0 +: ST_W];
      end
      if (start) begin
        busy_q <= 1'b1;
        samp_q <= 1'b1;
        pcnt   <= '0;
        scnt   <= '0;
        sar_q  <= '0;
        res_l  <= wr_data[12];
        div_l  <= wr_data[6 +: DIV_W];
        st_l   <= wr_data[0 +: ST_W];
      end else if (busy_q) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) begin
          if (samp_q) begin
            if (scnt == samp_last) begin
              samp_q <= 1'b0;
              sar_q  <= ONE << MSB_IDX;
              bidx   <= MSB_IDX;
            end else begin
              scnt <= scnt + 1'b1;
            end
          end else if (bidx == lsb_idx) begin
            result_q <= sar_keep;
            sar_q    <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            sar_q <= sar_keep | (ONE << (bidx - 1'b1));
            bidx  <= bidx - 1'b1;
          end
        end
      end
    end
  end

  assign ctrl_rd   = {mode_q, samp_q, busy_q, res_q, div_q, st_q};
  assign busy      = busy_q;
  assign sampling  = samp_q;
  assign done      = done_q;
  assign result    = result_q;
  assign sar_trial = sar_q;
endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sampling,
  input logic        done,
  input logic [15:0] ctrl_rd,
  input logic [9:0]  result,
  input logic        res_l
);
  a_r4_sample_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ctrl_rd[15] == $past(ctrl_rd[15]));

  a_r6_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_l) |-> result[1:0] == 2'b00);
endmodule

bind adc_seq_timer adc_seq_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sampling(sampling), .done(done),
  .ctrl_rd(ctrl_rd), .result(result), .res_l(res_l)
);

// File: tb/adc_seq_timer_tb.sv
module adc_seq_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [9:0]  vin = '0;
  logic        cmp_in;
  logic [15:0] ctrl_rd;
  logic        busy, sampling, done;
  logic [9:0]  result, sar_trial;
  int          n_run = 0, n_fail = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_in = (sar_trial <= vin);

  adc_seq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cmp_in(cmp_in),
    .ctrl_rd(ctrl_rd), .busy(busy), .sampling(sampling), .done(done),
    .result(result), .sar_trial(sar_trial)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] word(input bit md, input bit st, input bit rs,
                                       input int dv, input int sm);
    return {md, 1'b0, st, rs, 6'(dv), 6'(sm)};
  endfunction

  // Issues a start then counts negedges until done; optional mid-run write
  task automatic convert(input bit rs, input int dv, input int sm, input logic [9:0] v,
                         input bit poke, input logic [15:0] poke_word, input string tag);
    int n = 0, s = 0, mirror_bad = 0;
    int nb = rs ? 8 : 10;
    int exp_s = 4 * (sm + 1) * (dv + 1);
    int exp_t = (4 * (sm + 1) + nb) * (dv + 1);
    logic [9:0] exp_r = rs ? (v & 10'h3FC) : v;
    vin = v;
    wr(word(1'b0, 1'b1, rs, dv, sm));
    while (!done && n < 40000) begin
      if (sampling) s++;
      if (ctrl_rd[14] !== sampling || ctrl_rd[13] !== busy) mirror_bad++;
      if (poke && n == 5) begin
        wr_en = 1'b1; wr_data = poke_word;
        @(negedge clk);
        wr_en = 1'b0;
      end else begin
        @(negedge clk);
      end
      n++;
    end
    check(n == exp_t, {tag, " R6 R3 conversion length"}, n, exp_t);
    check(s == exp_s, {tag, " R4 sample length"}, s, exp_s);
    check(mirror_bad == 0, {tag, " R2 R4 status mirror"}, mirror_bad, 0);
    check(result == exp_r, {tag, " R5 R6 result"}, result, exp_r);
    check(!busy, {tag, " R7 busy low with done"}, busy, 0);
    @(negedge clk);
    check(!done, {tag, " R7 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check(ctrl_rd == 16'h1000, "R1 control reset", ctrl_rd, 16'h1000);
    check(!busy && !sampling && !done, "R1 status reset", {busy, sampling, done}, 0);
    check(result == 0, "R1 result reset", result, 0);
  endtask

  task automatic t_start();
    vin = 10'h0;
    wr_en = 1'b1; wr_data = word(1'b0, 1'b1, 1'b0, 1, 0);
    check(!busy, "R2 idle before start", busy, 0);
    @(negedge clk);
    wr_en = 1'b0;
    check(busy && sampling, "R2 busy after start", {busy, sampling}, 3);
    check(sar_trial == 0, "R5 trial clear while sampling", sar_trial, 0);
    repeat (7) @(negedge clk);
    check(sampling, "R4 still sampling", sampling, 1);
    @(negedge clk);
    check(!sampling && sar_trial == 10'h200, "R5 msb trial first", sar_trial, 10'h200);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_ten();
    convert(1'b0, 1, 0, 10'h2A5, 1'b0, 16'h0, "ten");
    convert(1'b0, 0, 0, 10'h3FF, 1'b0, 16'h0, "ten_full");
    convert(1'b0, 0, 0, 10'h000, 1'b0, 16'h0, "ten_zero");
  endtask

  task automatic t_eight();
    convert(1'b1, 3, 2, 10'h1FF, 1'b0, 16'h0, "eight");
    convert(1'b1, 0, 1, 10'h3FF, 1'b0, 16'h0, "eight_full");
  endtask

  task automatic t_busy_writes();
    logic [15:0] pw = word(1'b1, 1'b1, 1'b1, 5, 3);
    convert(1'b0, 1, 0, 10'h155, 1'b1, pw, "busy_poke R8 R10");
    check(ctrl_rd[15] == 1'b0, "R9 mode kept while busy", ctrl_rd[15], 0);
    check(ctrl_rd[12:0] == pw[12:0] & 13'h1FFF & ~13'h0, "R10 fields visible",
          ctrl_rd[12:0], {pw[12], pw[11:0]});
    wr(word(1'b1, 1'b0, 1'b0, 2, 1));
    check(ctrl_rd[15] == 1'b1, "R9 mode written when idle", ctrl_rd[15], 1);
    check(!busy, "R2 no start without start bit", busy, 0);
    convert(1'b1, 5, 3, 10'h0C3, 1'b0, 16'h0, "next_uses_new R10");
  endtask

  task automatic t_long();
    convert(1'b0, 63, 63, 10'h155, 1'b0, 16'h0, "long R3 R4");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_ten();
        t_eight();
        t_busy_writes();
        t_long();
      end
      begin
        wait (cyc >= 150000);
        check(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule